// File: doc/BRIEF.md
# Timer Control Register Bank

This block is the shared control and status register file of a multi-channel timer unit. It holds four words: a channel enable word, a stop word that gates each channel's clock and also gates the watchdog, an event flag word, and an interrupt mask word. Each word has one address that reads it. It also has two alias addresses: one sets bits that are written as one, and the other clears them. Software can therefore change one channel without a read-modify-write sequence.

The counter channels report two kinds of match through `full_hit` and `half_hit`. The block latches these matches into the flag word and combines flags and mask into one interrupt line per channel. It also drives the per-channel enable and stop signals back to the counters. To start a channel, software clears its stop bit and then sets its enable bit. To halt it, software clears the enable bit and then sets the stop bit. The register port is a plain single-cycle write strobe with a combinational read. Reset is asserted asynchronously and is released through a two-stage synchroniser.

Top module: `tcr_bank`

## Requirements
- R1: While reset is active, and from then until the first write: the stop word reads with every channel bit set and bit 16 set; the enable and flag words read zero; the mask word reads with bit x and bit x+16 set for every channel; all `irq` outputs are low.
- R2: The words read at offset 0x10 (enable), 0x1C (stop), 0x20 (flag) and 0x30 (mask). Bits that have no channel or watchdog behind them read as zero.
- R3: A write to a set alias (enable 0x14, stop 0x2C, flag 0x24, mask 0x34) sets every implemented bit that is one in `wdata` and leaves the other bits unchanged.
- R4: A write to a clear alias (enable 0x18, stop 0x3C, flag 0x28, mask 0x38) clears every bit that is one in `wdata` and leaves the other bits unchanged.
- R5: A write to a plain read offset, or to any address that is not an alias, changes no register.
- R6: A read of any set or clear alias address returns zero.
- R7: `full_hit[x]` sets flag bit x and `half_hit[x]` sets flag bit x+16 on the same clock edge. The new value is visible on the read port after that edge.
- R8: If a hardware match and a clear-alias write to the same flag bit fall in the same cycle, the bit ends up set.
- R9: `irq[x]` is high when flag bit x is set and mask bit x is clear, or when flag bit x+16 is set and mask bit x+16 is clear.
- R10: `ch_en[x]` follows enable bit x, `ch_stop[x]` follows stop bit x, and `wdt_stop` follows stop bit 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| full_hit | input | NUM_CH | Full-period match pulse per channel |
| half_hit | input | NUM_CH | Half-period match pulse per channel |
| irq | output | NUM_CH | Interrupt per channel |
| ch_en | output | NUM_CH | Counter enable per channel |
| ch_stop | output | NUM_CH | Clock gate per channel, high stops the channel |
| wdt_stop | output | 1 | High stops the watchdog clock |

## Verification
The case that is hardest to reach is a clear of a flag bit that lands in the same cycle as a match pulse on that bit. A software driver never lines these two up on purpose, so the bench drives the match pulse and the clear-alias write in one vector. It then reads the flag word back and expects the bit set while the other flags in the clear data are gone. The bench reaches the half-match interrupt path the same way: it unmasks only a channel's half bit and shows that `irq` rises from a bit-16-and-up flag alone.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned AW        = 8;
  localparam int unsigned HALF_BASE = 16;
  localparam int unsigned WDOG_BIT  = 16;
  localparam int unsigned NUM_WORDS = 4;

  // word indices
  localparam int unsigned IX_EN   = 0;
  localparam int unsigned IX_STOP = 1;
  localparam int unsigned IX_FLAG = 2;
  localparam int unsigned IX_MASK = 3;

  // offsets software depends on
  localparam logic [AW-1:0] OFS_EN_RD    = 8'h10;
  localparam logic [AW-1:0] OFS_EN_SET   = 8'h14;
  localparam logic [AW-1:0] OFS_EN_CLR   = 8'h18;
  localparam logic [AW-1:0] OFS_STOP_RD  = 8'h1C;
  localparam logic [AW-1:0] OFS_STOP_SET = 8'h2C;
  localparam logic [AW-1:0] OFS_STOP_CLR = 8'h3C;
  localparam logic [AW-1:0] OFS_FLAG_RD  = 8'h20;
  localparam logic [AW-1:0] OFS_FLAG_SET = 8'h24;
  localparam logic [AW-1:0] OFS_FLAG_CLR = 8'h28;
  localparam logic [AW-1:0] OFS_MASK_RD  = 8'h30;
  localparam logic [AW-1:0] OFS_MASK_SET = 8'h34;
  localparam logic [AW-1:0] OFS_MASK_CLR = 8'h38;
endpackage

// File: rtl/tcr_rst_sync.sv
module tcr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tcr_addr_dec.sv
module tcr_addr_dec
  import tcr_pkg::*;
(
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  output logic [NUM_WORDS-1:0] set_we,
  output logic [NUM_WORDS-1:0] clr_we,
  output logic                 rd_hit,
  output logic [1:0]           rd_idx
);
  always_comb begin
    set_we = '0;
    clr_we = '0;
    rd_hit = 1'b0;
    rd_idx = 2'd0;
    unique case (addr)
      OFS_EN_RD:    begin rd_hit = 1'b1; rd_idx = 2'(IX_EN);   end
      OFS_STOP_RD:  begin rd_hit = 1'b1; rd_idx = 2'(IX_STOP); end
      OFS_FLAG_RD:  begin rd_hit = 1'b1; rd_idx = 2'(IX_FLAG); end
      OFS_MASK_RD:  begin rd_hit = 1'b1; rd_idx = 2'(IX_MASK); end
      OFS_EN_SET:   set_we[IX_EN]   = wr_en;
      OFS_STOP_SET: set_we[IX_STOP] = wr_en;
      OFS_FLAG_SET: set_we[IX_FLAG] = wr_en;
      OFS_MASK_SET: set_we[IX_MASK] = wr_en;
      OFS_EN_CLR:   clr_we[IX_EN]   = wr_en;
      OFS_STOP_CLR: clr_we[IX_STOP] = wr_en;
      OFS_FLAG_CLR: clr_we[IX_FLAG] = wr_en;
      OFS_MASK_CLR: clr_we[IX_MASK] = wr_en;
      default: ;
    endcase
  end
endmodule

// File: rtl/tcr_sc_word.sv
module tcr_sc_word #(
  parameter int unsigned WIDTH   = 32,
  parameter logic [WIDTH-1:0] IMPL    = '1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] hw_set,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;
  logic             load;

  always_comb begin
    load = set_we | clr_we | (|hw_set);
    q_d  = q;
    if (set_we) q_d = q_d | wdata;
    if (clr_we) q_d = q_d & ~wdata;
    q_d = (q_d | hw_set) & IMPL;  // hardware set overrides a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= q_d;
  end

  // R8: a hardware event always leaves its bit set
  p_hw_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_set & IMPL)) |=> ((q & $past(hw_set & IMPL)) == $past(hw_set & IMPL)));

  // R5: no write and no event means the word holds
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we && hw_set == '0) |=> $stable(q));
endmodule

// File: rtl/tcr_irq_merge.sv
module tcr_irq_merge
  import tcr_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [DW-1:0]     flag,
  input  logic [DW-1:0]     mask,
  output logic [NUM_CH-1:0] irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign irq[c] = (flag[c] & ~mask[c]) |
                    (flag[HALF_BASE + c] & ~mask[HALF_BASE + c]);
  end
endmodule

// File: rtl/tcr_bank.sv
module tcr_bank
  import tcr_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NUM_CH-1:0] full_hit,
  input  logic [NUM_CH-1:0] half_hit,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] ch_stop,
  output logic              wdt_stop
);
  localparam logic [DW-1:0] CH_BITS   = {{(DW-NUM_CH){1'b0}}, {NUM_CH{1'b1}}};
  localparam logic [DW-1:0] PAIR_BITS = CH_BITS | (CH_BITS << HALF_BASE);
  localparam logic [DW-1:0] STOP_BITS = CH_BITS | (DW'(1) << WDOG_BIT);

  logic                 rst_sync_n;
  logic [NUM_WORDS-1:0] set_we, clr_we;
  logic                 rd_hit;
  logic [1:0]           rd_idx;
  logic [DW-1:0]        hw_word;
  logic [DW-1:0]        word_q [NUM_WORDS];

  tcr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tcr_addr_dec u_dec (
    .wr_en  (wr_en),
    .addr   (addr),
    .set_we (set_we),
    .clr_we (clr_we),
    .rd_hit (rd_hit),
    .rd_idx (rd_idx)
  );

  always_comb begin
    hw_word = '0;
    hw_word[NUM_CH-1:0]           = full_hit;
    hw_word[HALF_BASE +: NUM_CH]  = half_hit;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [DW-1:0] IMPL =
      (w == IX_STOP) ? STOP_BITS : (w == IX_EN) ? CH_BITS : PAIR_BITS;
    localparam logic [DW-1:0] RSTV =
      (w == IX_STOP) ? STOP_BITS : (w == IX_MASK) ? PAIR_BITS : '0;
    logic [DW-1:0] hw_in;
    assign hw_in = (w == IX_FLAG) ? hw_word : '0;

    tcr_sc_word #(.WIDTH(DW), .IMPL(IMPL), .RST_VAL(RSTV)) u_word (
      .clk    (clk),
      .rst_n  (rst_n & rst_sync_n),
      .set_we (set_we[w]),
      .clr_we (clr_we[w]),
      .wdata  (wdata),
      .hw_set (hw_in),
      .q      (word_q[w])
    );
  end

  assign rdata = rd_hit ? word_q[rd_idx] : '0;

  tcr_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
    .flag (word_q[IX_FLAG]),
    .mask (word_q[IX_MASK]),
    .irq  (irq)
  );

  assign ch_en    = word_q[IX_EN][NUM_CH-1:0];
  assign ch_stop  = word_q[IX_STOP][NUM_CH-1:0];
  assign wdt_stop = word_q[IX_STOP][WDOG_BIT];

  // R3: set alias raises the written enable bits
  p_en_set_r3: assert property (@(posedge clk) disable iff (!(rst_n && rst_sync_n))
    (wr_en && addr == OFS_EN_SET) |=>
      ((ch_en & $past(wdata[NUM_CH-1:0])) == $past(wdata[NUM_CH-1:0])));

  // R4: clear alias drops the written enable bits
  p_en_clr_r4: assert property (@(posedge clk) disable iff (!(rst_n && rst_sync_n))
    (wr_en && addr == OFS_EN_CLR) |=> ((ch_en & $past(wdata[NUM_CH-1:0])) == '0));

  // R10: clearing bit 16 of the stop word lets the watchdog run
  p_wdt_run_r10: assert property (@(posedge clk) disable iff (!(rst_n && rst_sync_n))
    (wr_en && addr == OFS_STOP_CLR && wdata[WDOG_BIT]) |=> !wdt_stop);

  // R9: a fully masked word blocks every interrupt
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!(rst_n && rst_sync_n))
    ((word_q[IX_MASK] & PAIR_BITS) == PAIR_BITS) |-> (irq == '0));
endmodule

// File: tb/tcr_bank_tb.sv
module tcr_bank_tb;
  localparam int  NCH     = 8;
  localparam time CLK_PER = 10ns;

  typedef struct packed {
    logic        wr;
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  fh;
    logic [7:0]  hh;
    logic [7:0]  ra;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h3C, 32'h0000_0003, 8'h00, 8'h00, 8'h1C, 32'h0001_00FC, 8'd4},  // R4 stop clear
    '{1'b1, 8'h14, 32'h0000_0003, 8'h00, 8'h00, 8'h10, 32'h0000_0003, 8'd3},  // R3 enable set
    '{1'b1, 8'h10, 32'h0000_00FF, 8'h00, 8'h00, 8'h10, 32'h0000_0003, 8'd5},  // R5 plain write
    '{1'b0, 8'h00, 32'h0000_0000, 8'h00, 8'h00, 8'h14, 32'h0000_0000, 8'd6},  // R6 alias reads 0
    '{1'b0, 8'h00, 32'h0000_0000, 8'h01, 8'h00, 8'h20, 32'h0000_0001, 8'd7},  // R7 full match
    '{1'b0, 8'h00, 32'h0000_0000, 8'h00, 8'h02, 8'h20, 32'h0002_0001, 8'd7},  // R7 half match
    '{1'b1, 8'h38, 32'h0000_0001, 8'h00, 8'h00, 8'h30, 32'h00FF_00FE, 8'd4},  // R4 mask clear
    '{1'b1, 8'h28, 32'h0002_0001, 8'h01, 8'h00, 8'h20, 32'h0000_0001, 8'd8},  // R8 set beats clear
    '{1'b1, 8'h3C, 32'h0001_0000, 8'h00, 8'h00, 8'h1C, 32'h0000_00FC, 8'd4},  // R4 watchdog run
    '{1'b1, 8'h24, 32'hFFFF_FFFF, 8'h00, 8'h00, 8'h20, 32'h00FF_00FF, 8'd3},  // R3 flag set, R2 unimpl
    '{1'b1, 8'h18, 32'h0000_0001, 8'h00, 8'h00, 8'h10, 32'h0000_0002, 8'd4},  // R4 enable clear
    '{1'b1, 8'h40, 32'hFFFF_FFFF, 8'h00, 8'h00, 8'h10, 32'h0000_0002, 8'd5}   // R5 stray address
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [7:0]     addr;
  logic [31:0]    wdata;
  logic [31:0]    rdata;
  logic [NCH-1:0] full_hit, half_hit, irq, ch_en, ch_stop;
  logic           wdt_stop;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  tcr_bank #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .full_hit(full_hit), .half_hit(half_hit), .irq(irq),
    .ch_en(ch_en), .ch_stop(ch_stop), .wdt_stop(wdt_stop)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] f, input logic [NCH-1:0] h);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; full_hit = f; half_hit = h;
    @(negedge clk);
    wr_en = 1'b0; full_hit = '0; half_hit = '0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; full_hit = '0; half_hit = '0;
    #(CLK_PER*2 + CLK_PER/4);
    // R1 and R2: reset values at the read offsets
    read_chk("R1 stop", 8'h1C, 32'h0001_00FF);
    read_chk("R1 enable", 8'h10, 32'h0000_0000);
    read_chk("R1 flag", 8'h20, 32'h0000_0000);
    read_chk("R2 mask", 8'h30, 32'h00FF_00FF);
    check("R1 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].wa, VECS[i].wd, VECS[i].fh, VECS[i].hh);
      read_chk($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].ra, VECS[i].exp);
    end

    // flag = 00FF_00FF, mask = 00FF_00FE
    check("R9 irq full path", 32'(irq), 32'h01);
    step(1'b1, 8'h38, 32'h0002_0000, '0, '0);
    check("R9 irq half path", 32'(irq), 32'h03);
    check("R10 ch_en", 32'(ch_en), 32'h02);
    check("R10 ch_stop", 32'(ch_stop), 32'hFC);
    check("R10 wdt_stop", 32'(wdt_stop), 32'h0);
    step(1'b1, 8'h2C, 32'h0001_0000, '0, '0);
    check("R10 wdt stopped", 32'(wdt_stop), 32'h1);
    step(1'b1, 8'h28, 32'h0000_0001, '0, '0);
    check("R9 flag cleared", 32'(irq), 32'h02);
    read_chk("R6 clear alias", 8'h38, 32'h0);

    // R1: asynchronous reset takes effect without a clock edge
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    read_chk("R1 async enable", 8'h10, 32'h0);
    check("R1 async irq", 32'(irq), 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PER * 5000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule